// File: doc/BRIEF.md
# Bus Data Trace Message Encoder

This block snoops completed load/store bus cycles. For each access that passes the trace filter, it builds one variable-length data trace message. The filter checks the trace enable, an inclusive address window, a per-direction enable for reads and writes, and the abort flag. Each message is packed least significant bit first: a 6-bit type code, then an address field, then the data value. A separate output gives the total bit count.

Most messages carry a compressed address. The encoder XORs the access address with the address of the previous traced data message and drops the leading zero bits, so a short hop costs only a few bits. A synchronization message carries the full 25-bit address instead. One is sent for the first traced access after reset or after the trace enable is turned on again, and then after every 255 compressed messages.

The output is a single message register with a valid/ready handshake. If an access qualifies while that register is stalled, the access is lost. The encoder reports the loss with an overflow error message and then sends a synchronization message, so a decoder can pick up the address chain again.

Top module: `dtrace_encoder`

## Requirements
- R1: A message is produced only for an access with `bus_valid_i` high, `bus_abort_i` low and `trace_en_i` high, whose address lies in [`range_lo_i`, `range_hi_i`] (both limits inclusive), and whose direction is enabled (`wr_trace_en_i` for writes, `rd_trace_en_i` for reads). Any other cycle produces no message.
- R2: The type code sits in bits [5:0]. Compressed write messages use code 5 and compressed read messages use code 6. The address field starts at bit 6. The data field follows directly after the address field. `msg_len_o` equals 6 + address field length + data field length.
- R3: The compressed address field is the current address XOR the last traced address. Its length is the index of the highest set bit plus one. If the XOR is zero, the field is a single 0 bit.
- R4: Size code 0 gives an 8-bit data field. Code 1 gives a 16-bit field, or a 24-bit zero-extended field when `full_port_i` is high. Codes 2 and 3 give a 32-bit field.
- R5: The first message after reset, and the first after `trace_en_i` has been low, is a synchronization message: code 13 for a write or 14 for a read, with the full 25-bit address as the address field. Every data message, compressed or not, reloads the last traced address.
- R6: After a synchronization message, 255 compressed messages are sent. The 256th data message is a synchronization message.
- R7: While `msg_valid_o` is high and `msg_ready_i` is low, `msg_valid_o`, `msg_o` and `msg_len_o` hold their values.
- R8: A qualifying access that arrives while the output is stalled is dropped. The next message is an error message: code 8 in bits [5:0], overflow code 1 in bits [10:6], length 11. An access that arrives in the cycle the error is loaded is dropped as well. The next data message after the error is a synchronization message.
- R9: A message is registered on the clock edge that samples the access. It is valid from the next cycle, provided the output register is empty or is being read in that same cycle.
- R10: While `rst_ni` is low, `msg_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trace_en_i | input | 1 | Trace enable |
| full_port_i | input | 1 | Widen 16-bit data fields to 24 bits |
| wr_trace_en_i | input | 1 | Trace write accesses |
| rd_trace_en_i | input | 1 | Trace read accesses |
| range_lo_i | input | 25 | Lowest traced address |
| range_hi_i | input | 25 | Highest traced address |
| bus_valid_i | input | 1 | Completed bus cycle |
| bus_abort_i | input | 1 | Cycle was aborted |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_size_i | input | 2 | 0 = 8 bit, 1 = 16 bit, 2/3 = 32 bit |
| bus_addr_i | input | 25 | Access address |
| bus_data_i | input | 32 | Access data |
| msg_ready_i | input | 1 | Consumer takes the message |
| msg_valid_o | output | 1 | Message present |
| msg_o | output | 63 | Packed message, LSB first |
| msg_len_o | output | 6 | Message length in bits |

## Verification
A wrong last-address register does not show up in the field width alone. It shows as a wrong XOR value and a wrong field length in the very next compressed message, and every later data message also shifts the data field to the wrong bit position. A wrong synchronization counter or flag changes the type code from 5/6 to 13/14 (or the other way round) and moves the length by a known number of bits in a single message. It is caught at the first message after the enable toggle, or at message 256 of a run. A lost overflow flag shows one cycle after a stall is released: a data message or an empty output appears where the 11-bit error message should be.

// File: rtl/dtrace_pkg.sv
package dtrace_pkg;
  localparam int TCODE_W = 6;
  localparam int ERR_W   = 5;

  typedef enum logic [TCODE_W-1:0] {
    TC_WR    = 6'd5,
    TC_RD    = 6'd6,
    TC_ERR   = 6'd8,
    TC_WSYNC = 6'd13,
    TC_RSYNC = 6'd14
  } tcode_e;

  localparam logic [ERR_W-1:0] ERR_OVF = 5'd1;

  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2,
    SZ_32B = 2'd3
  } size_e;
endpackage

// File: rtl/dtrace_filter.sv
module dtrace_filter #(
  parameter int ADDR_W = 25
) (
  input  logic              en_i,
  input  logic              valid_i,
  input  logic              abort_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic              qual_o
);
  logic in_range, dir_ok;
  assign in_range = (addr_i >= lo_i) && (addr_i <= hi_i);
  assign dir_ok   = we_i ? wr_en_i : rd_en_i;
  assign qual_o   = en_i && valid_i && !abort_i && in_range && dir_ok;
endmodule

// File: rtl/dtrace_addr_comp.sv
module dtrace_addr_comp #(
  parameter int ADDR_W = 25,
  parameter int LEN_W  = 6
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [ADDR_W-1:0] last_i,
  input  logic              full_i,
  output logic [ADDR_W-1:0] field_o,
  output logic [LEN_W-1:0]  len_o
);
  logic [ADDR_W-1:0] diff;
  logic [LEN_W-1:0]  trim_len;

  assign diff = cur_i ^ last_i;

  // highest set bit + 1, never below one bit
  always_comb begin
    trim_len = LEN_W'(1);
    for (int i = 1; i < ADDR_W; i++) begin
      if (diff[i]) trim_len = LEN_W'(i + 1);
    end
  end

  assign field_o = full_i ? cur_i : diff;
  assign len_o   = full_i ? LEN_W'(ADDR_W) : trim_len;
endmodule

// File: rtl/dtrace_data_fmt.sv
module dtrace_data_fmt #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic [1:0]        size_i,
  input  logic              full_port_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] field_o,
  output logic [LEN_W-1:0]  len_o
);
  import dtrace_pkg::*;

  always_comb begin
    unique case (size_e'(size_i))
      SZ_8: begin
        field_o = DATA_W'(data_i[7:0]);
        len_o   = LEN_W'(8);
      end
      SZ_16: begin
        field_o = DATA_W'(data_i[15:0]);
        len_o   = full_port_i ? LEN_W'(24) : LEN_W'(16);
      end
      default: begin
        field_o = data_i;
        len_o   = LEN_W'(DATA_W);
      end
    endcase
  end
endmodule

// File: rtl/dtrace_msg_pack.sv
module dtrace_msg_pack #(
  parameter int ADDR_W = 25,
  parameter int DATA_W = 32,
  parameter int MSG_W  = 63,
  parameter int LEN_W  = 6
) (
  input  logic [dtrace_pkg::TCODE_W-1:0] tcode_i,
  input  logic [ADDR_W-1:0]              afield_i,
  input  logic [LEN_W-1:0]               alen_i,
  input  logic [DATA_W-1:0]              dfield_i,
  input  logic [LEN_W-1:0]               dlen_i,
  output logic [MSG_W-1:0]               msg_o,
  output logic [LEN_W-1:0]               len_o
);
  import dtrace_pkg::*;

  assign msg_o = MSG_W'(tcode_i)
               | (MSG_W'(afield_i) << TCODE_W)
               | (MSG_W'(dfield_i) << (TCODE_W + int'(alen_i)));
  assign len_o = LEN_W'(TCODE_W) + alen_i + dlen_i;
endmodule

// File: rtl/dtrace_encoder.sv
module dtrace_encoder #(
  parameter int ADDR_W      = 25,
  parameter int DATA_W      = 32,
  parameter int SYNC_PERIOD = 255
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trace_en_i,
  input  logic              full_port_i,
  input  logic              wr_trace_en_i,
  input  logic              rd_trace_en_i,
  input  logic [ADDR_W-1:0] range_lo_i,
  input  logic [ADDR_W-1:0] range_hi_i,
  input  logic              bus_valid_i,
  input  logic              bus_abort_i,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_size_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              msg_ready_i,
  output logic              msg_valid_o,
  output logic [dtrace_pkg::TCODE_W+ADDR_W+DATA_W-1:0] msg_o,
  output logic [$clog2(dtrace_pkg::TCODE_W+ADDR_W+DATA_W+1)-1:0] msg_len_o
);
  import dtrace_pkg::*;

  localparam int MSG_W = TCODE_W + ADDR_W + DATA_W;
  localparam int LEN_W = $clog2(MSG_W + 1);
  localparam int CNT_W = $clog2(SYNC_PERIOD + 1);

  logic              valid_q;
  logic [MSG_W-1:0]  msg_q;
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] last_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sync_need_q;
  logic              ovf_q;

  logic              qual, slot_free, do_sync;
  logic [TCODE_W-1:0] tcode;
  logic [ADDR_W-1:0] afield;
  logic [LEN_W-1:0]  alen, dlen, dmsg_len;
  logic [DATA_W-1:0] dfield;
  logic [MSG_W-1:0]  dmsg;

  dtrace_filter #(.ADDR_W(ADDR_W)) u_filter (
    .en_i    (trace_en_i),
    .valid_i (bus_valid_i),
    .abort_i (bus_abort_i),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .lo_i    (range_lo_i),
    .hi_i    (range_hi_i),
    .wr_en_i (wr_trace_en_i),
    .rd_en_i (rd_trace_en_i),
    .qual_o  (qual)
  );

  assign do_sync = sync_need_q || (cnt_q == CNT_W'(SYNC_PERIOD));

  dtrace_addr_comp #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr (
    .cur_i   (bus_addr_i),
    .last_i  (last_q),
    .full_i  (do_sync),
    .field_o (afield),
    .len_o   (alen)
  );

  dtrace_data_fmt #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_data (
    .size_i      (bus_size_i),
    .full_port_i (full_port_i),
    .data_i      (bus_data_i),
    .field_o     (dfield),
    .len_o       (dlen)
  );

  always_comb begin
    unique case ({do_sync, bus_we_i})
      2'b11:   tcode = TC_WSYNC;
      2'b10:   tcode = TC_RSYNC;
      2'b01:   tcode = TC_WR;
      default: tcode = TC_RD;
    endcase
  end

  dtrace_msg_pack #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MSG_W(MSG_W), .LEN_W(LEN_W)
  ) u_pack (
    .tcode_i  (tcode),
    .afield_i (afield),
    .alen_i   (alen),
    .dfield_i (dfield),
    .dlen_i   (dlen),
    .msg_o    (dmsg),
    .len_o    (dmsg_len)
  );

  assign slot_free = !valid_q || msg_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q     <= 1'b0;
      msg_q       <= '0;
      len_q       <= '0;
      last_q      <= '0;
      cnt_q       <= '0;
      sync_need_q <= 1'b1;
      ovf_q       <= 1'b0;
    end else begin
      if (!slot_free) begin
        if (qual) ovf_q <= 1'b1;
      end else if (ovf_q) begin
        // error slot; a coincident access is folded into this report
        valid_q     <= 1'b1;
        msg_q       <= MSG_W'(TC_ERR) | (MSG_W'(ERR_OVF) << TCODE_W);
        len_q       <= LEN_W'(TCODE_W + ERR_W);
        ovf_q       <= 1'b0;
        sync_need_q <= 1'b1;
      end else if (qual) begin
        valid_q <= 1'b1;
        msg_q   <= dmsg;
        len_q   <= dmsg_len;
        last_q  <= bus_addr_i;
        if (do_sync) begin
          cnt_q       <= '0;
          sync_need_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        valid_q <= 1'b0;
      end
      if (!trace_en_i) sync_need_q <= 1'b1;
    end
  end

  assign msg_valid_o = valid_q;
  assign msg_o       = msg_q;
  assign msg_len_o   = len_q;
endmodule

// File: rtl/dtrace_encoder_chk.sv
module dtrace_encoder_chk #(
  parameter int MSG_W = 63,
  parameter int LEN_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             msg_valid_o,
  input logic             msg_ready_i,
  input logic [MSG_W-1:0] msg_o,
  input logic [LEN_W-1:0] msg_len_o,
  input logic             bus_valid_i,
  input logic             bus_abort_i,
  input logic             ovf_q
);
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_o) && $stable(msg_len_o));

  assert_no_spurious_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!msg_valid_o || msg_ready_i) && !ovf_q && !(bus_valid_i && !bus_abort_i) |=> !msg_valid_o);

  assert_legal_msg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> (msg_len_o >= LEN_W'(11)) && (msg_len_o <= LEN_W'(63)) &&
      (msg_o[5:0] inside {6'd5, 6'd6, 6'd8, 6'd13, 6'd14}));

  assert_sync_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && (msg_o[5:0] inside {6'd13, 6'd14}) |-> msg_len_o >= LEN_W'(39));

  assert_err_fmt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && msg_o[5:0] == 6'd8 |-> msg_len_o == LEN_W'(11) && msg_o[10:6] == 5'd1);

  assert_err_follows_ovf_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovf_q) |-> msg_valid_o && msg_o[5:0] == 6'd8);
endmodule

bind dtrace_encoder dtrace_encoder_chk #(.MSG_W(MSG_W), .LEN_W(LEN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .msg_valid_o (msg_valid_o),
  .msg_ready_i (msg_ready_i),
  .msg_o       (msg_o),
  .msg_len_o   (msg_len_o),
  .bus_valid_i (bus_valid_i),
  .bus_abort_i (bus_abort_i),
  .ovf_q       (ovf_q)
);

// File: tb/tb_dtrace_encoder.sv
module tb_dtrace_encoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trace_en, full_port, wr_en, rd_en;
  logic [24:0] lo, hi;
  logic        bvalid, babort, bwe;
  logic [1:0]  bsize;
  logic [24:0] baddr;
  logic [31:0] bdata;
  logic        ready;
  logic        mvalid;
  logic [62:0] msg;
  logic [5:0]  mlen;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  dtrace_encoder dut (
    .clk_i(clk), .rst_ni(rst_n), .trace_en_i(trace_en), .full_port_i(full_port),
    .wr_trace_en_i(wr_en), .rd_trace_en_i(rd_en), .range_lo_i(lo), .range_hi_i(hi),
    .bus_valid_i(bvalid), .bus_abort_i(babort), .bus_we_i(bwe), .bus_size_i(bsize),
    .bus_addr_i(baddr), .bus_data_i(bdata), .msg_ready_i(ready),
    .msg_valid_o(mvalid), .msg_o(msg), .msg_len_o(mlen)
  );

  typedef struct packed {
    logic        we;
    logic [1:0]  size;
    logic [24:0] addr;
    logic [31:0] data;
    logic [62:0] emsg;
    logic [5:0]  elen;
  } vec_t;

  // full_port high, whole range, both directions enabled, starting after reset
  localparam vec_t VECS [6] = '{
    '{1'b1, 2'd2, 25'h0001000, 32'hDEADBEEF,
      63'(13) | (63'(25'h0001000) << 6) | (63'(32'hDEADBEEF) << 31), 6'd63},
    '{1'b1, 2'd0, 25'h0001004, 32'h123456A5,
      63'(5) | (63'(3'b100) << 6) | (63'(8'hA5) << 9), 6'd17},
    '{1'b0, 2'd1, 25'h0001005, 32'hFFFF00C3,
      63'(6) | (63'(1) << 6) | (63'(24'h0000C3) << 7), 6'd31},
    '{1'b0, 2'd2, 25'h0001005, 32'h89ABCDEF,
      63'(6) | (63'(32'h89ABCDEF) << 7), 6'd39},
    '{1'b1, 2'd1, 25'h1800005, 32'h0000BEEF,
      63'(5) | (63'(25'h1801000) << 6) | (63'(32'h0000BEEF) << 31), 6'd55},
    '{1'b1, 2'd3, 25'h1800004, 32'h01020304,
      63'(5) | (63'(1) << 6) | (63'(32'h01020304) << 7), 6'd39}
  };

  task automatic chk(input string tag, input logic ok, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_msg(input string tag, input logic [62:0] emsg, input logic [5:0] elen);
    chk({tag, " valid"}, mvalid === 1'b1, 64'(mvalid), 64'd1);
    chk({tag, " msg"}, msg === emsg, 64'(msg), 64'(emsg));
    chk({tag, " len"}, mlen === elen, 64'(mlen), 64'(elen));
  endtask

  task automatic chk_none(input string tag);
    chk(tag, mvalid === 1'b0, 64'(mvalid), 64'd0);
  endtask

  // one-cycle access; returns at the negedge after the sampling edge
  task automatic send(input logic we, input logic [1:0] sz, input logic [24:0] a,
                      input logic [31:0] d, input logic ab);
    @(negedge clk);
    bvalid = 1'b1; bwe = we; bsize = sz; baddr = a; bdata = d; babort = ab;
    @(negedge clk);
    bvalid = 1'b0; babort = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    trace_en = 1'b1; full_port = 1'b1; wr_en = 1'b1; rd_en = 1'b1;
    lo = '0; hi = 25'h1FFFFFF;
    bvalid = 1'b0; babort = 1'b0; bwe = 1'b0; bsize = '0; baddr = '0; bdata = '0;
    ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 reset valid", mvalid === 1'b0, 64'(mvalid), 64'd0);
    rst_n = 1'b1;

    // R2 R3 R4 R5 R9: table walk
    for (int i = 0; i < 6; i++) begin
      send(VECS[i].we, VECS[i].size, VECS[i].addr, VECS[i].data, 1'b0);
      chk_msg($sformatf("R2/R3/R4/R9 vec%0d", i), VECS[i].emsg, VECS[i].elen);
    end

    // R1 filter: window 0x100..0x1FF
    lo = 25'h100; hi = 25'h1FF;
    send(1'b1, 2'd0, 25'h200, 32'h11, 1'b0);
    chk_none("R1 above window");
    send(1'b1, 2'd0, 25'h0FF, 32'h11, 1'b0);
    chk_none("R1 below window");
    send(1'b1, 2'd0, 25'h1FF, 32'h11, 1'b0);
    chk_msg("R1 upper limit inclusive",
            63'(5) | (63'(25'h18001FB) << 6) | (63'(8'h11) << 31), 6'd39);
    send(1'b1, 2'd0, 25'h1FF, 32'h11, 1'b1);
    chk_none("R1 aborted");
    wr_en = 1'b0;
    send(1'b1, 2'd0, 25'h100, 32'h11, 1'b0);
    chk_none("R1 write disabled");
    wr_en = 1'b1;
    trace_en = 1'b0;
    send(1'b0, 2'd0, 25'h180, 32'h11, 1'b0);
    chk_none("R1 trace disabled");
    trace_en = 1'b1;

    // R5 resync after enable, last address reload
    send(1'b0, 2'd0, 25'h180, 32'h22, 1'b0);
    chk_msg("R5 read sync", 63'(14) | (63'(25'h180) << 6) | (63'(8'h22) << 31), 6'd39);
    send(1'b0, 2'd0, 25'h182, 32'h33, 1'b0);
    chk_msg("R5 reload relative", 63'(6) | (63'(2'b10) << 6) | (63'(8'h33) << 8), 6'd16);

    // R4 half port: 16-bit stays 16
    full_port = 1'b0;
    send(1'b1, 2'd1, 25'h183, 32'h5555ABCD, 1'b0);
    chk_msg("R4 16-bit narrow", 63'(5) | (63'(1) << 6) | (63'(16'hABCD) << 7), 6'd23);
    full_port = 1'b1;

    // R7 R8 stall and overflow
    @(negedge clk);
    ready = 1'b0;
    send(1'b1, 2'd0, 25'h184, 32'h44, 1'b0);
    chk_msg("R7 stalled msg", 63'(5) | (63'(3'b111) << 6) | (63'(8'h44) << 9), 6'd17);
    send(1'b1, 2'd0, 25'h185, 32'h66, 1'b0);
    chk_msg("R7 hold during drop", 63'(5) | (63'(3'b111) << 6) | (63'(8'h44) << 9), 6'd17);
    ready = 1'b1;
    @(negedge clk);
    chk_msg("R8 error msg", 63'(8) | (63'(1) << 6), 6'd11);
    send(1'b1, 2'd0, 25'h190, 32'h55, 1'b0);
    chk_msg("R8 sync after error", 63'(13) | (63'(25'h190) << 6) | (63'(8'h55) << 31), 6'd39);

    // R6 periodic sync
    begin
      int bad = 0;
      for (int k = 0; k < 255; k++) begin
        send(1'b1, 2'd0, 25'h190, 32'h0, 1'b0);
        if (!(mvalid === 1'b1 && msg === 63'(5) && mlen === 6'd15)) bad++;
      end
      chk("R6 255 compressed msgs", bad == 0, 64'(bad), 64'd0);
    end
    send(1'b1, 2'd0, 25'h190, 32'h0, 1'b0);
    chk_msg("R6 periodic sync", 63'(13) | (63'(25'h190) << 6), 6'd39);
    send(1'b1, 2'd0, 25'h191, 32'h0, 1'b0);
    chk_msg("R6 compressed after sync", 63'(5) | (63'(1) << 6), 6'd15);

    @(negedge clk);
    chk_none("R9 drained");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule